// File: doc/BRIEF.md
# Valid-ready word deserializer

This block gathers a stream of narrow words into a wide array. Each word arrives on a valid/ready input port and is accepted in a cycle where both `in_valid` and `in_ready` are high. The words are stored in order into `SLOTS` registers. After the last register is written, the block stops taking input and offers the whole array at once on a valid/ready output port. A typical consumer is the input stage of a transform engine.

Inside, a two-state controller holds a write counter. A one-hot decoder turns that counter into one write enable per accepted word, and a generate loop builds one resettable register per output slot. Once the consumer takes the array, collection starts again at slot 0. The registers are not cleared at this point; each one keeps its old word until it is overwritten.

Top module: `vr_deser`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), `in_ready` is 1, `out_valid` is 0 and every bit of `out_words` is 0.
- R2: While collecting, `in_ready` is 1 and `out_valid` is 0. A word is taken only at an edge where `in_valid` and `in_ready` are both high.
- R3: The k-th word accepted after reset or after an output handshake (k counted from 0) appears in `out_words[k*WORD_W +: WORD_W]`.
- R4: Exactly one slot write enable is active for each accepted word and none otherwise. Slots not yet written in the current round keep their previous contents.
- R5: The cycle after the `SLOTS`-th accepted word, `out_valid` is 1 and `in_ready` is 0.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1, `out_words` stays unchanged, and `in_valid` has no effect.
- R7: After an edge with `out_valid` and `out_ready` both high, `in_ready` is 1 and `out_valid` is 0 in the next cycle. The next accepted word goes to slot 0, and `out_words` keeps its old contents until the slots are overwritten.
- R8: Cycles with `in_valid` low during collection leave `out_words` and the write position unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word is valid |
| in_ready | output | 1 | Block can take a word |
| in_word | input | WORD_W | Incoming word |
| out_valid | output | 1 | Full array is available |
| out_ready | input | 1 | Consumer takes the array |
| out_words | output | SLOTS*WORD_W | Array; slot k at bits k*WORD_W upward |

## Verification
The assertions check the following on every cycle:
- the two ready/valid flags are never high or low together;
- the write enables are one-hot only on an accepted word;
- the array is frozen during a stalled output and during input gaps;
- the output becomes valid only after exactly `SLOTS` accepts since the last release.

Only the bench's scenarios can show that each word lands in its own slot, in arrival order. The same holds for stale slot contents surviving into the next round, and for a reset in the middle of a round restarting at slot 0.

// File: rtl/vr_deser_pkg.sv
`timescale 1ns/1ps
package vr_deser_pkg;

    // Controller phase: gathering words, or holding a full array
    typedef enum logic {
        PH_FILL = 1'b0,
        PH_HOLD = 1'b1
    } phase_e;

endpackage

// File: rtl/deser_ctrl.sv
`timescale 1ns/1ps
module deser_ctrl #(
    parameter int SLOTS = 4,
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             out_ready,
    output logic             in_ready,
    output logic             out_valid,
    output logic             accept,
    output logic [CNT_W-1:0] wr_idx
);
    import vr_deser_pkg::*;

    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(SLOTS - 1);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
    } ctrl_s;

    ctrl_s st_d, st_q;

    assign in_ready  = (st_q.phase == PH_FILL);
    assign out_valid = (st_q.phase == PH_HOLD);
    assign accept    = in_valid && in_ready;
    assign wr_idx    = st_q.cnt;

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_FILL: begin
                if (accept) begin
                    if (st_q.cnt == LAST_IDX) begin
                        st_d.cnt   = '0;
                        st_d.phase = PH_HOLD;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            PH_HOLD: begin
                if (out_ready) begin
                    st_d.phase = PH_FILL;
                end
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{phase: PH_FILL, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/deser_onehot.sv
`timescale 1ns/1ps
module deser_onehot #(
    parameter int SLOTS = 4,
    parameter int CNT_W = 2
) (
    input  logic             en,
    input  logic [CNT_W-1:0] idx,
    output logic [SLOTS-1:0] sel
);
    for (genvar i = 0; i < SLOTS; i++) begin : g_bit
        assign sel[i] = en && (idx == CNT_W'(i));
    end
endmodule

// File: rtl/deser_slot.sv
`timescale 1ns/1ps
module deser_slot #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] q
);
    logic [WORD_W-1:0] data_d, data_q;

    always_comb begin
        data_d = data_q;
        if (we) begin
            data_d = din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else begin
            data_q <= data_d;
        end
    end

    assign q = data_q;
endmodule

// File: rtl/vr_deser.sv
`timescale 1ns/1ps
module vr_deser #(
    parameter int WORD_W = 8,
    parameter int SLOTS  = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic [WORD_W-1:0]         in_word,
    output logic                      out_valid,
    input  logic                      out_ready,
    output logic [SLOTS*WORD_W-1:0]   out_words
);
    localparam int CNT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    logic             accept;
    logic [CNT_W-1:0] wr_idx;
    logic [SLOTS-1:0] slot_we;

    deser_ctrl #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .accept    (accept),
        .wr_idx    (wr_idx)
    );

    deser_onehot #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_dec (
        .en  (accept),
        .idx (wr_idx),
        .sel (slot_we)
    );

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        deser_slot #(.WORD_W(WORD_W)) u_slot (
            .clk (clk),
            .rst (rst),
            .we  (slot_we[s]),
            .din (in_word),
            .q   (out_words[s*WORD_W +: WORD_W])
        );
    end

endmodule

// File: rtl/vr_deser_chk.sv
`timescale 1ns/1ps
module vr_deser_chk #(
    parameter int WORD_W = 8,
    parameter int SLOTS  = 4
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic                    in_ready,
    input logic                    out_valid,
    input logic                    out_ready,
    input logic [SLOTS*WORD_W-1:0] out_words,
    input logic [SLOTS-1:0]        slot_we
);
    localparam int AW = $clog2(SLOTS + 1) + 1;
    localparam logic [AW-1:0] FULL_CNT = AW'(SLOTS);

    logic [AW-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (out_valid && out_ready) begin
            acc_q <= '0;
        end else if (in_valid && in_ready) begin
            acc_q <= acc_q + 1'b1;
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (in_ready && !out_valid && out_words == '0));

    // R2
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        in_ready != out_valid);

    // R4
    we_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(slot_we) && ((in_valid && in_ready) == ($countones(slot_we) == 1)));

    // R5
    full_after_n_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> (acc_q == FULL_CNT));

    // R5
    no_overfill_chk: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> (acc_q < FULL_CNT));

    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_words)));

    // R7
    release_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready) |=> (in_ready && !out_valid));

    // R8
    idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !in_valid) |=> $stable(out_words));

endmodule

bind vr_deser vr_deser_chk #(.WORD_W(WORD_W), .SLOTS(SLOTS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_words (out_words),
    .slot_we   (slot_we)
);

// File: tb/vr_deser_test.sv
`timescale 1ns/1ps
module vr_deser_test;
    localparam int WORD_W = 8;
    localparam int SLOTS  = 4;
    localparam int FLAT   = WORD_W * SLOTS;

    logic              clk = 1'b0;
    logic              rst;
    logic              in_valid;
    logic              in_ready;
    logic [WORD_W-1:0] in_word;
    logic              out_valid;
    logic              out_ready;
    logic [FLAT-1:0]   out_words;

    int total = 0;
    int bad   = 0;
    logic [WORD_W-1:0] exp_w [SLOTS];

    always #10 clk = ~clk;

    vr_deser #(.WORD_W(WORD_W), .SLOTS(SLOTS)) uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_word   (in_word),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_words (out_words)
    );

    function automatic logic [FLAT-1:0] exp_flat();
        logic [FLAT-1:0] v = '0;
        for (int s = 0; s < SLOTS; s++) v[s*WORD_W +: WORD_W] = exp_w[s];
        return v;
    endfunction

    function automatic logic [WORD_W-1:0] word_of(int f, int k);
        return WORD_W'(f * 37 + k * 11 + f * k * 3 + 5);
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, expv, $time);
        end
    endtask

    task automatic check_words(input string req);
        check(out_words == exp_flat(), req, 64'(out_words), 64'(exp_flat()));
    endtask

    task automatic run_frame(input int f);
        for (int k = 0; k < SLOTS; k++) begin
            repeat ((f + k) % 3) @(negedge clk);
            // R8: gaps leave the array alone; R2: still collecting
            check_words("R8");
            check(in_ready && !out_valid, "R2", {in_ready, out_valid}, 2'b10);
            in_valid = 1'b1;
            in_word  = word_of(f, k);
            @(negedge clk);
            in_valid = 1'b0;
            exp_w[k] = word_of(f, k);
            // R3, R4: slot k written, other slots keep old values
            check_words("R3");
            if (k < SLOTS - 1)
                check(in_ready && !out_valid, "R2", {in_ready, out_valid}, 2'b10);
            else
                check(!in_ready && out_valid, "R5", {in_ready, out_valid}, 2'b01);
        end
        out_ready = 1'b0;
        in_valid  = 1'b1;
        for (int n = 0; n < (f * 7) % 5 + 1; n++) begin
            in_word = ~word_of(f, n);
            @(negedge clk);
            check(out_valid && !in_ready, "R6", {in_ready, out_valid}, 2'b01);
            check_words("R6");
        end
        in_valid  = 1'b0;
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        check(in_ready && !out_valid, "R7", {in_ready, out_valid}, 2'b10);
        check_words("R7");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0; in_word = '0;
        for (int s = 0; s < SLOTS; s++) exp_w[s] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1
        check(in_ready && !out_valid, "R1", {in_ready, out_valid}, 2'b10);
        check_words("R1");

        for (int f = 0; f < 6; f++) run_frame(f);

        // mid-round reset: two words, then reset, then a full round from slot 0
        for (int k = 0; k < 2; k++) begin
            in_valid = 1'b1;
            in_word  = 8'hA0 + WORD_W'(k);
            @(negedge clk);
        end
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int s = 0; s < SLOTS; s++) exp_w[s] = '0;
        check(in_ready && !out_valid, "R1", {in_ready, out_valid}, 2'b10);
        check_words("R1");
        run_frame(6);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule